// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the 16x oversampling tick of a serial receiver and transmitter from a reference clock. The rate is a rational fraction of the reference rather than an integer division of it. Software loads a numerator and a denominator, each stored as its value minus one. On every reference step an accumulator adds the numerator. Whenever the sum reaches the denominator, the denominator is taken off and one tick goes out. The 16x tick rate is therefore ref × (num+1)/(den+1). A requested baud rate is met by choosing num+1 = baud/100 and den+1 = ref/1600.

The reference can first be slowed by a selectable pre-divider of 1 to 7. A second counter, loaded with the number of reference steps in one millisecond, gives a millisecond strobe from the same pre-divided reference. A single enable gates the whole block. While it is low every counter sits at zero and no output pulses.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, and on the cycle after it falls, both tick outputs are low. Reset loads numerator 0, denominator 0, millisecond length 0 and divider code 5 (divide by 1). With enable high and no writes, tick_16x is therefore high on every cycle after reset, and tick_ms never pulses.
- R2: When num <= den, tick_16x pulses for one cycle at most per reference step. Over the first n reference steps after a restart it pulses floor(n × (num+1)/(den+1)) times. Its first possible pulse follows the first reference step.
- R3: When num > den, tick_16x is high after every reference step.
- R4: A write takes effect when wr_en is high at a clock edge, with wr_data holding the value. wr_sel 0 selects the numerator, 1 the denominator, 2 the millisecond length and 3 the divider, whose code is taken from wr_data[9:7]. A write to the numerator or denominator clears the accumulator and tick_16x.
- R5: The divider code sets the reference step as one in every F clock cycles: code 5 gives F=1, 4 gives 2, 3 gives 3, 2 gives 4, 1 gives 5, 0 gives 6, 6 gives 7 and 7 gives 1. With F>1, the first step after a restart is the F-th clock cycle.
- R6: With a millisecond length N>0, tick_ms pulses once every N reference steps, first after the N-th step following a restart. N=0 gives no strobe. A write to the millisecond length restarts its count.
- R7: While enable is low, neither tick output pulses and all counters hold at zero. Once enable rises again, the block behaves as if just restarted.
- R8: Every 16-bit numerator and denominator value, including a denominator of 65535 (a divisor of 65536), gives the exact count of R2 or R3.
- R9: A write to the divider restarts the pre-divider, the accumulator and the millisecond counter together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low holds everything at zero |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 numerator, 1 denominator, 2 millisecond length, 3 divider |
| wr_data | input | 16 | Write data; divider code in bits [9:7] |
| tick_16x | output | 1 | One-cycle 16x oversampling tick |
| tick_ms | output | 1 | One-cycle millisecond strobe |

## Verification
The ratio pair is swept across all 64 combinations of numerator and denominator from 0 to 7, with the tick count checked over a fixed window. This separates exact fractional stepping from rounding and off-by-one faults, and the cases above the diagonal catch missing saturation. Each of the eight divider codes is run at a unit ratio, which exposes any mistake in the non-monotonic code mapping. The millisecond lengths 0, 1 and 7, a pre-divided millisecond run, and a near one-third ratio with a 65536 divisor check the strobe and the accumulator width. Disabling and then re-enabling the block shows that no ticks pass while it is off and that it restarts from a clean phase.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int REG_W        = 16;
    localparam int DIV_CODE_W   = 3;
    localparam int DIV_CODE_LSB = 7;

    localparam logic [DIV_CODE_W-1:0] DIV_CODE_RESET = 3'd5;

    typedef enum logic [1:0] {
        SEL_NUM = 2'd0,
        SEL_DEN = 2'd1,
        SEL_MS  = 2'd2,
        SEL_DIV = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ratio;   // numerator or denominator written
        logic ms;      // millisecond length written
        logic all;     // divider written: restart everything
    } restart_t;

    // Span is the divide factor minus one; code 7 is treated as divide by 1.
    function automatic logic [DIV_CODE_W-1:0] div_span(input logic [DIV_CODE_W-1:0] code);
        logic [DIV_CODE_W-1:0] span;
        case (code)
            3'd5:    span = 3'd0;
            3'd4:    span = 3'd1;
            3'd3:    span = 3'd2;
            3'd2:    span = 3'd3;
            3'd1:    span = 3'd4;
            3'd0:    span = 3'd5;
            3'd6:    span = 3'd6;
            default: span = 3'd0;
        endcase
        return span;
    endfunction

endpackage

// File: rtl/frac_cfg_regs.sv
module frac_cfg_regs
    import frac_baud_pkg::*;
#(
    parameter int WIDTH = REG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      num,
    output logic [WIDTH-1:0]      den,
    output logic [WIDTH-1:0]      ms_len,
    output logic [DIV_CODE_W-1:0] span,
    output restart_t              restart
);

    reg_sel_e               sel;
    logic [DIV_CODE_W-1:0]  code_q;
    logic [DIV_CODE_W-1:0]  code_in;

    assign sel     = reg_sel_e'(wr_sel);
    assign code_in = wr_data[DIV_CODE_LSB +: DIV_CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            num    <= '0;
            den    <= '0;
            ms_len <= '0;
            code_q <= DIV_CODE_RESET;
        end else if (wr_en) begin
            case (sel)
                SEL_NUM: num    <= wr_data;
                SEL_DEN: den    <= wr_data;
                SEL_MS:  ms_len <= wr_data;
                SEL_DIV: code_q <= code_in;
                default: ;
            endcase
        end
    end

    assign span = div_span(code_q);

    always_comb begin
        restart       = '0;
        restart.ratio = wr_en && (sel == SEL_NUM || sel == SEL_DEN);
        restart.ms    = wr_en && (sel == SEL_MS);
        restart.all   = wr_en && (sel == SEL_DIV);
    end

endmodule

// File: rtl/frac_prediv.sv
module frac_prediv
    import frac_baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  restart,
    input  logic [DIV_CODE_W-1:0] span,
    output logic                  ref_en
);

    logic [DIV_CODE_W-1:0] cnt_q;
    logic                  wrap;

    assign wrap   = (cnt_q == span);
    assign ref_en = enable && !restart && wrap;

    always_ff @(posedge clk) begin
        if (rst || !enable || restart) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic             ref_en,
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    output logic [WIDTH:0]   acc,
    output logic             tick
);

    localparam int AW = WIDTH + 1;
    localparam int SW = WIDTH + 2;

    logic [AW-1:0] step;
    logic [AW-1:0] limit;
    logic [SW-1:0] sum;
    logic          fast;
    logic          reach;

    assign step  = {1'b0, num} + 1'b1;
    assign limit = {1'b0, den} + 1'b1;
    assign sum   = {1'b0, acc} + {1'b0, step};
    assign fast  = (num > den);
    assign reach = (sum >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !enable || clear) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (ref_en) begin
            if (fast) begin
                acc  <= '0;
                tick <= 1'b1;
            end else if (reach) begin
                acc  <= AW'(sum - {1'b0, limit});
                tick <= 1'b1;
            end else begin
                acc  <= AW'(sum);
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_ms_timer.sv
module frac_ms_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             clear,
    input  logic             ref_en,
    input  logic [WIDTH-1:0] ms_len,
    output logic             strobe
);

    logic [WIDTH-1:0] cnt_q;
    logic             active;
    logic             last;

    assign active = (ms_len != '0);
    assign last   = (cnt_q == ms_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !enable || clear) begin
            cnt_q  <= '0;
            strobe <= 1'b0;
        end else if (ref_en && active) begin
            if (last) begin
                cnt_q  <= '0;
                strobe <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                strobe <= 1'b0;
            end
        end else begin
            strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int WIDTH = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic             tick_16x,
    output logic             tick_ms
);

    logic [WIDTH-1:0]      num_q;
    logic [WIDTH-1:0]      den_q;
    logic [WIDTH-1:0]      ms_len_q;
    logic [DIV_CODE_W-1:0] span;
    restart_t              restart;
    logic                  ref_en;
    logic [WIDTH:0]        acc_q;
    logic                  acc_clear;
    logic                  ms_clear;

    assign acc_clear = restart.ratio || restart.all;
    assign ms_clear  = restart.ms || restart.all;

    frac_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .num     (num_q),
        .den     (den_q),
        .ms_len  (ms_len_q),
        .span    (span),
        .restart (restart)
    );

    frac_prediv u_prediv (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .restart (restart.all),
        .span    (span),
        .ref_en  (ref_en)
    );

    frac_accum #(.WIDTH(WIDTH)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .clear  (acc_clear),
        .ref_en (ref_en),
        .num    (num_q),
        .den    (den_q),
        .acc    (acc_q),
        .tick   (tick_16x)
    );

    frac_ms_timer #(.WIDTH(WIDTH)) u_ms (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .clear  (ms_clear),
        .ref_en (ref_en),
        .ms_len (ms_len_q),
        .strobe (tick_ms)
    );

endmodule

// File: rtl/frac_baud_checker.sv
module frac_baud_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             ref_en,
    input logic [WIDTH-1:0] num,
    input logic [WIDTH-1:0] den,
    input logic [WIDTH:0]   acc,
    input logic             tick_16x,
    input logic             tick_ms
);

    // R7: a disabled block emits nothing
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!tick_16x && !tick_ms));

    // R2, R5, R6: ticks only follow a reference step
    p_tick_needs_step_r2: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> (!tick_16x && !tick_ms));

    // R3: numerator above denominator saturates the tick
    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_en && !wr_en && (num > den)) |=> tick_16x);

    // R8: the accumulator never reaches the divisor
    p_acc_bound_r8: assert property (@(posedge clk) disable iff (rst)
        acc <= {1'b0, den});

    // R4: a ratio write clears the accumulator and the tick
    p_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1)) |=> (acc == '0 && !tick_16x));

endmodule

bind frac_baud_gen frac_baud_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .ref_en   (ref_en),
    .num      (num_q),
    .den      (den_q),
    .acc      (acc_q),
    .tick_16x (tick_16x),
    .tick_ms  (tick_ms)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tick_16x;
    logic        tick_ms;

    int checks = 0;
    int errors = 0;

    frac_baud_gen uut (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tick_16x (tick_16x),
        .tick_ms  (tick_ms)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count(input int n, output int t16, output int tms);
        t16 = 0;
        tms = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            t16 += int'(tick_16x);
            tms += int'(tick_ms);
        end
    endtask

    function automatic int factor(input int code);
        case (code)
            5: return 1;
            4: return 2;
            3: return 3;
            2: return 4;
            1: return 5;
            0: return 6;
            6: return 7;
            default: return 1;
        endcase
    endfunction

    function automatic longint exp_ticks(input longint steps, input longint n1, input longint d1);
        longint v;
        v = (steps * n1) / d1;
        return (v > steps) ? steps : v;
    endfunction

    initial begin
        int a, b;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick_16x in reset", tick_16x, 0);
        check("R1 tick_ms in reset", tick_ms, 0);
        rst = 1'b0;
        count(20, a, b);
        check("R1 default ratio ticks", a, 20);
        check("R1 default ms strobes", b, 0);

        // R2 / R3: ratio sweep at divide by 1
        for (int n = 0; n < 8; n++) begin
            for (int d = 0; d < 8; d++) begin
                wr(2'd0, 16'(n));
                wr(2'd1, 16'(d));
                count(48, a, b);
                check((n > d) ? "R3 saturated ratio" : "R2 ratio sweep",
                      a, exp_ticks(48, n + 1, d + 1));
            end
        end

        // R5 / R9: every divider code at unit ratio
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 16'd0);
            wr(2'd1, 16'd0);
            wr(2'd3, 16'(c << 7));
            count(42, a, b);
            check("R5 divider code", a, 42 / factor(c));
        end
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd4);
        wr(2'd3, 16'(2 << 7));
        count(40, a, b);
        check("R9 divided fractional ratio", a, exp_ticks(40 / 4, 3, 5));

        // R6: millisecond strobe
        wr(2'd3, 16'(5 << 7));
        wr(2'd2, 16'd7);
        count(50, a, b);
        check("R6 ms length 7", b, 50 / 7);
        wr(2'd2, 16'd1);
        count(50, a, b);
        check("R6 ms length 1", b, 50);
        wr(2'd2, 16'd0);
        count(50, a, b);
        check("R6 ms length 0", b, 0);
        wr(2'd2, 16'd4);
        wr(2'd3, 16'(3 << 7));
        count(60, a, b);
        check("R9 ms after divide by 3", b, (60 / 3) / 4);

        // R8: wide accumulator
        wr(2'd0, 16'd21844);
        wr(2'd1, 16'd65535);
        wr(2'd3, 16'(5 << 7));
        count(60, a, b);
        check("R8 wide divisor", a, exp_ticks(60, 21845, 65536));
        wr(2'd0, 16'd65535);
        count(10, a, b);
        check("R8 full scale equal", a, 10);
        wr(2'd1, 16'd65534);
        count(10, a, b);
        check("R3 full scale above", a, 10);

        // R4: field positions honoured; code outside bits [9:7] ignored
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd3, 16'h0004 | 16'(2 << 7));
        count(40, a, b);
        check("R4 code field position", a, 10);

        // R7: enable gating
        wr(2'd3, 16'(5 << 7));
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        @(negedge clk);
        enable = 1'b0;
        count(30, a, b);
        check("R7 disabled ticks", a, 0);
        check("R7 disabled ms", b, 0);
        enable = 1'b1;
        count(30, a, b);
        check("R7 restart ticks", a, exp_ticks(30, 2, 3));
        check("R7 restart ms", b, 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule